// File: doc/BRIEF.md
# Interrupt Controller with Set/Clear Enable Registers

This block gathers `NSRC` level-sensitive interrupt inputs and raises a single request line towards a processor. Each source may be enabled by a mask register bit alone, or by a mask bit together with a priority field. The block holds one counter per source that tracks how many of its enable contributions are active. A source takes part in arbitration only when that counter reaches the number of contributions the source requires.

Software never writes a mask or priority register directly. Each register has a set address, where the write data is ORed into the stored value, and a clear address, where the bits given in the write data are removed from it. A read from either address returns the stored value.

The vector output presents the code of the lowest-indexed pending source, together with a valid flag. This output is a live level and has no ready input, so there is no back-pressure. The code changes as soon as the pending set changes, and the processor samples it whenever it chooses to. When the processor's interrupt mask level input is 0xF, the valid flag is held low.

Top module: `mskint_ctrl`

## Requirements
- R1: Source i needs mask bit NSRC-1-i set. For i < NPRI it also needs priority field i to be nonzero, so that it has 2 contributions; every other source has 1. It is enabled only when all of its contributions are active.
- R2: A source is pending only while its input level is high and it is enabled. A high input on a disabled source has no effect on `irq` or on the vector output.
- R3: Address 0 is the mask set address and address 2 is the priority set address. A write to either ORs the write data into the stored value; the mask register is the low NSRC bits and the priority register is the low NPRI*FW bits.
- R4: Address 1 is the mask clear address and address 3 is the priority clear address. A write to either stores the old value AND the inverse of the write data.
- R5: `irq` is high exactly while at least one source is pending. It stays high while any pending source remains, and it falls when the last one leaves.
- R6: Priority field i occupies bits [(NPRI-1-i)*FW +: FW], so the most significant field belongs to source 0. Only a change between zero and nonzero alters the enable state; a change from one nonzero value to another does nothing.
- R7: When a source is pending and `imask` is not 0xF, `vec_valid` is high and `vec_code` is VEC_BASE + VEC_STEP*i for the lowest pending index i. Otherwise `vec_valid` is low and `vec_code` is 0.
- R8: After reset, both registers read 0, no source is pending, and `irq` and `vec_valid` are low.
- R9: Reading either mask address returns the stored mask value and reading either priority address returns the stored priority value, zero-extended to DW bits.
- R10: A change of an input level shows on `irq` and on the vector output after one rising clock edge. A register write shows after two edges. Holding an input high longer changes nothing.
- R11: Setting a bit that is already set, or clearing a bit that is already clear, leaves the enable counts unchanged. A later single clear of that bit therefore disables the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| src_lvl | input | NSRC | Interrupt source levels, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 mask set, 1 mask clear, 2 priority set, 3 priority clear) |
| wdata | input | DW | Write data |
| rdata | output | DW | Stored value of the addressed register |
| imask | input | 4 | Processor interrupt mask level |
| irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector output is valid |
| vec_code | output | VW | Vector code of the winning source |

## Verification
The assertions assume that the source levels are already synchronous to `clk`. They also assume that a bus write touches one register per cycle, which means a source's enable counter moves by at most one step per edge. The bench drives every input at the falling edge, so each write and level change lands at a single rising edge. It samples outputs at a later falling edge and compares them with a reference model of the mask and priority values that it updates itself.

// File: rtl/mskint_pkg.sv
package mskint_pkg;
  typedef enum logic [1:0] {
    ADR_MSK_SET = 2'd0,
    ADR_MSK_CLR = 2'd1,
    ADR_PRI_SET = 2'd2,
    ADR_PRI_CLR = 2'd3
  } adr_e;
endpackage

// File: rtl/mskint_regs.sv
module mskint_regs
  import mskint_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int NPRI = 4,
  parameter int FW   = 4,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NSRC-1:0]    mask_q,
  output logic [NPRI*FW-1:0] prio_q,
  output logic [NSRC-1:0]    msk_up,
  output logic [NSRC-1:0]    msk_dn,
  output logic [NPRI-1:0]    pri_up,
  output logic [NPRI-1:0]    pri_dn
);
  localparam int PW = NPRI * FW;

  logic [NSRC-1:0] mask_d;
  logic [PW-1:0]   prio_d;

  // next register values: set ORs in, clear removes
  always_comb begin
    mask_d = mask_q;
    prio_d = prio_q;
    if (wr_en) begin
      case (addr)
        ADR_MSK_SET: mask_d = mask_q | wdata[NSRC-1:0];
        ADR_MSK_CLR: mask_d = mask_q & ~wdata[NSRC-1:0];
        ADR_PRI_SET: prio_d = prio_q | wdata[PW-1:0];
        default:     prio_d = prio_q & ~wdata[PW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      mask_q <= mask_d;
      prio_q <= prio_d;
    end
  end

  // only bits that actually change produce a contribution step
  assign msk_up = mask_d & ~mask_q;
  assign msk_dn = mask_q & ~mask_d;

  // field of source s sits at (NPRI-1-s)*FW, most significant first
  for (genvar s = 0; s < NPRI; s++) begin : g_fld
    logic old_nz, new_nz;
    assign old_nz    = |prio_q[(NPRI-1-s)*FW +: FW];
    assign new_nz    = |prio_d[(NPRI-1-s)*FW +: FW];
    assign pri_up[s] = new_nz & ~old_nz;
    assign pri_dn[s] = old_nz & ~new_nz;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_MSK_SET || addr == ADR_MSK_CLR) rdata[NSRC-1:0] = mask_q;
    else                                            rdata[PW-1:0]   = prio_q;
  end

  p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_MSK_SET) |=>
      ((mask_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
  p_pset_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_PRI_SET) |=>
      ((prio_q & $past(wdata[PW-1:0])) == $past(wdata[PW-1:0])));
  p_clr_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_MSK_CLR) |=> ((mask_q & $past(wdata[NSRC-1:0])) == '0));
  p_pclr_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_PRI_CLR) |=> ((prio_q & $past(wdata[PW-1:0])) == '0));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_q) && $stable(prio_q)));
endmodule

// File: rtl/mskint_src.sv
module mskint_src #(
  parameter int MAXC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic up,
  input  logic dn,
  output logic full,
  output logic pend_nx,
  output logic pend_q
);
  logic [1:0] cnt_q;

  assign full    = (cnt_q == 2'(MAXC));
  assign pend_nx = lvl & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + {1'b0, up} - {1'b0, dn};
      pend_q <= pend_nx;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 2'(MAXC));
  p_step_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));
  p_pend_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lvl) |-> !pend_q);
  p_pend_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(full) |-> !pend_q);
endmodule

// File: rtl/mskint_arb.sv
module mskint_arb #(
  parameter int NSRC     = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_nx,
  input  logic [NSRC-1:0] pend_q,
  input  logic [3:0]      imask,
  output logic            irq,
  output logic            vec_valid,
  output logic [VW-1:0]   vec_code
);
  localparam int CW = $clog2(NSRC + 1);

  logic [CW-1:0] npend_q;
  logic          hit;
  logic [VW-1:0] code;

  // running count of pending sources, stepped by entries and exits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) npend_q <= '0;
    else npend_q <= npend_q + CW'($countones(pend_nx & ~pend_q))
                            - CW'($countones(pend_q & ~pend_nx));
  end

  assign irq = (npend_q != '0);

  // scan downwards so the lowest pending index is assigned last
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        hit  = 1'b1;
        code = VW'(VEC_BASE + VEC_STEP * i);
      end
    end
  end

  assign vec_valid = hit && (imask != 4'hF);
  assign vec_code  = vec_valid ? code : '0;

  p_npend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    npend_q == CW'($countones(pend_q)));
  p_irq_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|pend_q));
  p_lvl_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == 4'hF) |-> !vec_valid);
  p_valid_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> irq);
endmodule

// File: rtl/mskint_ctrl.sv
module mskint_ctrl #(
  parameter int NSRC     = 8,
  parameter int NPRI     = 4,
  parameter int FW       = 4,
  parameter int DW       = 16,
  parameter int VW       = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [3:0]      imask,
  output logic            irq,
  output logic            vec_valid,
  output logic [VW-1:0]   vec_code
);
  localparam int PW = NPRI * FW;

  logic [NSRC-1:0] mask_q, msk_up, msk_dn;
  logic [PW-1:0]   prio_q;
  logic [NPRI-1:0] pri_up, pri_dn;
  logic [NSRC-1:0] full, pend_nx, pend_q;

  mskint_regs #(.NSRC(NSRC), .NPRI(NPRI), .FW(FW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mask_q(mask_q), .prio_q(prio_q),
    .msk_up(msk_up), .msk_dn(msk_dn), .pri_up(pri_up), .pri_dn(pri_dn)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic up, dn;
    if (i < NPRI) begin : g_two
      assign up = msk_up[NSRC-1-i] | pri_up[i];
      assign dn = msk_dn[NSRC-1-i] | pri_dn[i];
      p_full_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full[i] == (mask_q[NSRC-1-i] && (|prio_q[(NPRI-1-i)*FW +: FW])));
    end else begin : g_one
      assign up = msk_up[NSRC-1-i];
      assign dn = msk_dn[NSRC-1-i];
      p_full_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full[i] == mask_q[NSRC-1-i]);
    end
    mskint_src #(.MAXC(i < NPRI ? 2 : 1)) u_src (
      .clk(clk), .rst_n(rst_n), .lvl(src_lvl[i]), .up(up), .dn(dn),
      .full(full[i]), .pend_nx(pend_nx[i]), .pend_q(pend_q[i])
    );
  end

  mskint_arb #(.NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_nx(pend_nx), .pend_q(pend_q),
    .imask(imask), .irq(irq), .vec_valid(vec_valid), .vec_code(vec_code)
  );
endmodule

// File: tb/sim_mskint_ctrl.sv
module sim_mskint_ctrl;
  localparam int NSRC = 8, NPRI = 4, FW = 4, DW = 16, VW = 8;
  localparam int VEC_BASE = 64, VEC_STEP = 4;
  localparam int PW = NPRI * FW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_lvl = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic [3:0]      imask = 4'h0;
  logic            irq, vec_valid;
  logic [VW-1:0]   vec_code;

  int total = 0, bad = 0;
  bit done = 0;
  logic [NSRC-1:0] mask_m = '0;
  logic [PW-1:0]   prio_m = '0;

  always #4 clk = ~clk;

  mskint_ctrl #(.NSRC(NSRC), .NPRI(NPRI), .FW(FW), .DW(DW), .VW(VW),
                .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .imask(imask), .irq(irq),
    .vec_valid(vec_valid), .vec_code(vec_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      2'd0: mask_m = mask_m | d[NSRC-1:0];
      2'd1: mask_m = mask_m & ~d[NSRC-1:0];
      2'd2: prio_m = prio_m | d[PW-1:0];
      default: prio_m = prio_m & ~d[PW-1:0];
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [NSRC-1:0] exp_pend();
    logic [NSRC-1:0] p = '0;
    for (int i = 0; i < NSRC; i++) begin
      logic en;
      en = mask_m[NSRC-1-i];
      if (i < NPRI) en = en && (|prio_m[(NPRI-1-i)*FW +: FW]);
      p[i] = src_lvl[i] && en;
    end
    return p;
  endfunction

  task automatic check_outs(input string req);
    logic [NSRC-1:0] p;
    logic            v;
    logic [VW-1:0]   c;
    p = exp_pend();
    v = 1'b0; c = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (p[i]) begin v = 1'b1; c = VW'(VEC_BASE + VEC_STEP * i); end
    if (imask == 4'hF) v = 1'b0;
    if (!v) c = '0;
    chk({req, " irq"}, 32'(irq), 32'(|p));
    chk({req, " valid"}, 32'(vec_valid), 32'(v));
    chk({req, " code"}, 32'(vec_code), 32'(c));
  endtask

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk({req, " rdata"}, 32'(rdata), 32'(exp));
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) rd(2'(a), '0, "R8 reset");
    chk("R8 reset irq", 32'(irq), 0);
    chk("R8 reset valid", 32'(vec_valid), 0);
    src_lvl = '1;
    settle();
    chk("R2 disabled irq", 32'(irq), 0);
    src_lvl = '0;
  endtask

  task automatic t_setclr();
    wr(2'd0, 16'h00A5);
    rd(2'd0, 16'h00A5, "R3 mask set");
    wr(2'd0, 16'h0010);
    rd(2'd1, 16'h00B5, "R9 mask read at clear addr");
    wr(2'd1, 16'h0081);
    rd(2'd0, 16'h0034, "R4 mask clear");
    wr(2'd2, 16'h1200);
    rd(2'd3, 16'h1200, "R9 prio read at clear addr");
    wr(2'd3, 16'h0200);
    rd(2'd2, 16'h1000, "R4 prio clear");
    wr(2'd1, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    rd(2'd0, 16'h0000, "R4 mask all clear");
  endtask

  task automatic t_mask_only();
    src_lvl = 8'h20;
    settle();
    check_outs("R2 src5 masked");
    wr(2'd0, 16'h0004);
    settle();
    check_outs("R1 src5 mask only");
    chk("R7 src5 code", 32'(vec_code), 32'(VEC_BASE + VEC_STEP * 5));
    wr(2'd1, 16'h0004);
    settle();
    check_outs("R1 src5 disabled");
    src_lvl = '0;
  endtask

  task automatic t_both();
    src_lvl = 8'h01;
    wr(2'd0, 16'h0080);
    settle();
    check_outs("R1 src0 mask without field");
    chk("R1 src0 no irq", 32'(irq), 0);
    wr(2'd2, 16'h2000);
    settle();
    check_outs("R6 src0 field nonzero");
    wr(2'd2, 16'h1000);
    settle();
    check_outs("R6 field nonzero to nonzero");
    wr(2'd3, 16'h2000);
    settle();
    check_outs("R6 field still nonzero");
    chk("R6 src0 stays", 32'(irq), 1);
    wr(2'd3, 16'h1000);
    settle();
    check_outs("R6 field zero");
    chk("R6 src0 off", 32'(irq), 0);
    wr(2'd2, 16'h0F00);
    settle();
    check_outs("R6 field of src1 does not enable src0");
    wr(2'd1, 16'h00FF);
    wr(2'd3, 16'hFFFF);
    src_lvl = '0;
  endtask

  task automatic t_count();
    wr(2'd0, 16'h00FF);
    wr(2'd2, 16'h1111);
    src_lvl = 8'h06;
    settle();
    check_outs("R5 two pending");
    src_lvl = 8'h04;
    settle();
    chk("R5 one left irq", 32'(irq), 1);
    check_outs("R5 one left");
    src_lvl = 8'h00;
    settle();
    chk("R5 none irq", 32'(irq), 0);
    check_outs("R5 none");
  endtask

  task automatic t_vector();
    src_lvl = 8'h28;
    settle();
    chk("R7 lowest code", 32'(vec_code), 32'(VEC_BASE + VEC_STEP * 3));
    check_outs("R7 two pending");
    imask = 4'hF;
    #1;
    chk("R7 imask F valid", 32'(vec_valid), 0);
    chk("R7 imask F irq", 32'(irq), 1);
    check_outs("R7 imask F");
    imask = 4'hE;
    #1;
    check_outs("R7 imask E");
    src_lvl = 8'hC0;
    settle();
    check_outs("R7 high sources");
    src_lvl = '0;
    imask = 4'h0;
    settle();
  endtask

  task automatic t_relevel();
    src_lvl = 8'h08;
    @(negedge clk);
    chk("R10 one edge irq", 32'(irq), 1);
    check_outs("R10 one edge");
    repeat (5) begin
      src_lvl = 8'h08;
      @(negedge clk);
    end
    check_outs("R10 held level");
    wr(2'd0, 16'h0010);
    settle();
    check_outs("R11 redundant set");
    wr(2'd1, 16'h0010);
    @(negedge clk);
    chk("R10 write two edges", 32'(irq), 0);
    check_outs("R11 single clear disables");
    wr(2'd1, 16'h0010);
    wr(2'd0, 16'h0010);
    settle();
    check_outs("R11 redundant clear then set");
    chk("R11 reenabled", 32'(irq), 1);
    src_lvl = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_mask_only();
    t_both();
    t_count();
    t_vector();
    t_relevel();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule